// File: doc/BRIEF.md
# Transport Stream PRBS Checker

This block checks a pseudo-random test pattern that travels inside the payload of 188-byte transport stream packets. Bytes arrive one per cycle when the valid input is high, and the start-of-packet input marks the sync byte. The sync byte and a programmable number of header bytes after it are never checked. Every remaining byte of the packet is a payload byte, and its eight bits, most significant bit first, feed a 23-stage reference generator for the sequence x^23 + x^18 + 1.

The checker synchronizes to the incoming sequence without outside help. It seeds its generator from 23 received payload bits, lets the generator run on its own, and declares lock after 64 further bits that all match. While locked it reports, one cycle after each checked payload byte, how many of that byte's bits differ from the reference. A downstream error counter can add these counts up. Checked bits are grouped into back-to-back windows of 256 bits. When one window collects more than 32 bit errors, lock is released and seeding starts again. The generator moves forward only on payload bits, so gaps, sync bytes and header bytes do not disturb the sequence.

Top module: `ts_prbs_checker`

## Requirements
- R1: The byte that carries start-of-packet (position 0), and the `hdr_len` bytes after it (positions 1 to `hdr_len`), are never checked. The remaining bytes, up to position 187, are checked. A byte is ignored when `in_valid` is low. Bytes that arrive before the first start-of-packet are ignored.
- R2: The expected value of each payload bit is the XOR of the payload bits 23 and 18 positions earlier in the payload bit stream. Bits are taken MSB first within a byte.
- R3: On a clean stream after reset or after lock is lost, the first 23 payload bits seed the generator. `prbs_locked` rises in the cycle after the byte that completes 64 further matching bits. That is the cycle after the 11th payload byte.
- R4: `err_valid` pulses for exactly one cycle after each payload byte that began while `prbs_locked` was high, and never at any other time.
- R5: With `err_valid` high, `err_bits` (0 to 8) is the number of bits in the byte that differ from the reference. With `err_valid` low, `err_bits` is 0.
- R6: Corrupted received bits do not disturb the reference. A clean byte that follows a corrupted byte reports 0 errors.
- R7: Checked bits form consecutive windows of 256 bits (32 locked bytes), and the first window starts at the first locked byte. Exactly 32 errors in a window keep lock.
- R8: When a window's error total exceeds 32, `prbs_locked` falls in the same cycle that reports the offending byte, and that byte is still reported. Seeding then restarts, and R3 timing applies again.
- R9: While `rst_n` is low and right after reset, `prbs_locked`, `err_valid` and `err_bits` are all 0.
- R10: A new `hdr_len` that is applied before a sync byte changes the number of checked bytes in that packet to 187 − `hdr_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hdr_len | input | 4 | Number of header bytes after the sync byte that are excluded from checking |
| in_byte | input | 8 | Received byte, MSB is the first bit in time |
| in_valid | input | 1 | `in_byte` carries a byte this cycle |
| in_sop | input | 1 | With `in_valid`, marks the sync byte of a packet |
| prbs_locked | output | 1 | Checker is synchronized to the sequence |
| err_valid | output | 1 | One-cycle strobe: `err_bits` holds the count for the last checked byte |
| err_bits | output | 4 | Number of erroneous bits in that byte |

## Verification
The properties assume that `in_sop` only comes with `in_valid`, and that `hdr_len` changes only between packets. The bench drives every byte through one task that sets all three inputs together. It raises `in_sop` alone only on idle cycles, where it must have no effect. It changes the header size only after a packet's last byte. The properties also assume that a loss of lock is caused by a reported byte with errors. The stimulus therefore corrupts only payload bytes, with masks whose bit counts are known, so every window total is known in the bench.

// File: rtl/ts_prbs_pkg.sv
// Shared types and constants for the transport stream PRBS checker.
package ts_prbs_pkg;
    // Acquisition phase of the sequence tracker
    typedef enum logic [1:0] {
        PH_SEED   = 2'd0,
        PH_VERIFY = 2'd1,
        PH_LOCK   = 2'd2
    } phase_e;

    localparam int PRBS_DEG = 23;
    localparam int PRBS_TAP = 18;
endpackage

// File: rtl/ts_payload_gate.sv
// Tracks the byte position inside a packet and flags payload bytes.
// Assumes in_sop only comes with in_valid. Before the first sop the
// position sits saturated at PKT_LEN, so no byte is treated as payload.
module ts_payload_gate #(
    parameter int PKT_LEN = 188,
    parameter int HDR_W   = 4,
    localparam int POS_W  = $clog2(PKT_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [HDR_W-1:0] hdr_len,
    output logic             pay_ok
);
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] hdr_ext;

    assign hdr_ext = {{(POS_W-HDR_W){1'b0}}, hdr_len};

    // Position of the byte expected next; restarts at 1 after a sync byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= POS_W'(PKT_LEN);
        end else if (in_valid) begin
            if (in_sop)
                pos_q <= POS_W'(1);
            else if (pos_q != POS_W'(PKT_LEN))
                pos_q <= pos_q + POS_W'(1);
        end
    end

    // Current byte is payload when past the header and inside the packet
    always_comb begin
        pay_ok = in_valid && !in_sop && (pos_q > hdr_ext) && (pos_q < POS_W'(PKT_LEN));
    end
endmodule

// File: rtl/prbs_byte_engine.sv
// Combinational step of the tracker across one byte, MSB first.
// In the seed phase received bits are shifted in. In the verify and
// lock phases the generator free-runs, and received bits are compared
// against its output.
module prbs_byte_engine
    import ts_prbs_pkg::*;
#(
    parameter int DEG       = PRBS_DEG,
    parameter int TAP       = PRBS_TAP,
    parameter int BYTE_W    = 8,
    parameter int LOCK_BITS = 64,
    localparam int CNT_W    = $clog2((DEG > LOCK_BITS ? DEG : LOCK_BITS) + 1),
    localparam int ERR_W    = $clog2(BYTE_W + 1)
) (
    input  logic [DEG-1:0]    lfsr_in,
    input  phase_e            phase_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [DEG-1:0]    lfsr_out,
    output phase_e            phase_out,
    output logic [CNT_W-1:0]  cnt_out,
    output logic [ERR_W-1:0]  err_cnt
);
    // Walk the eight bits in arrival order and update state per bit
    always_comb begin
        logic [DEG-1:0]   s;
        phase_e           ph;
        logic [CNT_W-1:0] c;
        logic [ERR_W-1:0] e;
        logic             pred;
        s = lfsr_in;
        ph = phase_in;
        c = cnt_in;
        e = '0;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            pred = s[DEG-1] ^ s[TAP-1];
            case (ph)
                PH_SEED: begin
                    s = {s[DEG-2:0], rx_byte[i]};
                    c = c + CNT_W'(1);
                    if (c == CNT_W'(DEG)) begin
                        ph = PH_VERIFY;
                        c = '0;
                    end
                end
                PH_VERIFY: begin
                    s = {s[DEG-2:0], pred};
                    if (rx_byte[i] != pred) begin
                        ph = PH_SEED;
                        c = '0;
                    end else begin
                        c = c + CNT_W'(1);
                        if (c == CNT_W'(LOCK_BITS)) begin
                            ph = PH_LOCK;
                            c = '0;
                        end
                    end
                end
                default: begin
                    s = {s[DEG-2:0], pred};
                    if (rx_byte[i] != pred)
                        e = e + ERR_W'(1);
                end
            endcase
        end
        lfsr_out = s;
        phase_out = ph;
        cnt_out = c;
        err_cnt = e;
    end
endmodule

// File: rtl/prbs_seq_tracker.sv
// Holds generator state, acquisition phase and bit counter. It advances
// only on payload bytes. A drop request forces a fresh seed phase.
module prbs_seq_tracker
    import ts_prbs_pkg::*;
#(
    parameter int DEG       = PRBS_DEG,
    parameter int TAP       = PRBS_TAP,
    parameter int BYTE_W    = 8,
    parameter int LOCK_BITS = 64,
    localparam int CNT_W    = $clog2((DEG > LOCK_BITS ? DEG : LOCK_BITS) + 1),
    localparam int ERR_W    = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              drop,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              locked,
    output logic [ERR_W-1:0]  err_cnt
);
    logic [DEG-1:0]   lfsr_q, lfsr_d;
    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    prbs_byte_engine #(
        .DEG(DEG), .TAP(TAP), .BYTE_W(BYTE_W), .LOCK_BITS(LOCK_BITS)
    ) u_engine (
        .lfsr_in  (lfsr_q),
        .phase_in (phase_q),
        .cnt_in   (cnt_q),
        .rx_byte  (rx_byte),
        .lfsr_out (lfsr_d),
        .phase_out(phase_d),
        .cnt_out  (cnt_d),
        .err_cnt  (err_cnt)
    );

    // Commit the byte step, or restart seeding when lock is dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q  <= '0;
            phase_q <= PH_SEED;
            cnt_q   <= '0;
        end else if (step) begin
            lfsr_q <= lfsr_d;
            if (drop) begin
                phase_q <= PH_SEED;
                cnt_q   <= '0;
            end else begin
                phase_q <= phase_d;
                cnt_q   <= cnt_d;
            end
        end
    end

    // Locked status comes straight from the phase register
    always_comb begin
        locked = (phase_q == PH_LOCK);
    end
endmodule

// File: rtl/prbs_err_window.sv
// Sums bit errors over back-to-back windows of locked bytes. It asks for
// a drop as soon as the running total passes the limit. Cleared while
// unlocked, so the first window starts with the first locked byte.
module prbs_err_window #(
    parameter int BYTE_W   = 8,
    parameter int WIN_BITS = 256,
    parameter int MAX_ERR  = 32,
    localparam int ERR_W     = $clog2(BYTE_W + 1),
    localparam int WIN_BYTES = WIN_BITS / BYTE_W,
    localparam int ACC_W     = $clog2(WIN_BITS + 1),
    localparam int WC_W      = $clog2(WIN_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             locked,
    input  logic             step,
    input  logic [ERR_W-1:0] err_cnt,
    output logic             drop
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [WC_W-1:0]  wcnt_q;

    // Running total including the byte being checked now
    always_comb begin
        sum  = acc_q + ACC_W'(err_cnt);
        drop = locked && step && (sum > ACC_W'(MAX_ERR));
    end

    // Accumulate per window; restart at window end, on drop, or unlocked
    always_ff @(posedge clk) begin
        if (!rst_n || !locked) begin
            acc_q  <= '0;
            wcnt_q <= '0;
        end else if (step) begin
            if (drop || wcnt_q == WC_W'(WIN_BYTES - 1)) begin
                acc_q  <= '0;
                wcnt_q <= '0;
            end else begin
                acc_q  <= sum;
                wcnt_q <= wcnt_q + WC_W'(1);
            end
        end
    end
endmodule

// File: rtl/ts_prbs_checker.sv
// Top of the PRBS checker. It gates payload bytes out of the packet stream,
// tracks the sequence, supervises the error rate and registers the per-byte
// error report. Assumes one byte per valid cycle and a packet of PKT_LEN.
module ts_prbs_checker
    import ts_prbs_pkg::*;
#(
    parameter int PKT_LEN   = 188,
    parameter int HDR_W     = 4,
    parameter int BYTE_W    = 8,
    parameter int LOCK_BITS = 64,
    parameter int WIN_BITS  = 256,
    parameter int MAX_ERR   = 32,
    localparam int ERR_W    = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HDR_W-1:0]  hdr_len,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    input  logic              in_sop,
    output logic              prbs_locked,
    output logic              err_valid,
    output logic [ERR_W-1:0]  err_bits
);
    logic             pay_ok;
    logic             drop;
    logic             locked;
    logic [ERR_W-1:0] err_cnt;

    ts_payload_gate #(.PKT_LEN(PKT_LEN), .HDR_W(HDR_W)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_sop  (in_sop),
        .hdr_len (hdr_len),
        .pay_ok  (pay_ok)
    );

    prbs_seq_tracker #(
        .DEG(PRBS_DEG), .TAP(PRBS_TAP), .BYTE_W(BYTE_W), .LOCK_BITS(LOCK_BITS)
    ) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (pay_ok),
        .drop   (drop),
        .rx_byte(in_byte),
        .locked (locked),
        .err_cnt(err_cnt)
    );

    prbs_err_window #(
        .BYTE_W(BYTE_W), .WIN_BITS(WIN_BITS), .MAX_ERR(MAX_ERR)
    ) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .locked (locked),
        .step   (pay_ok),
        .err_cnt(err_cnt),
        .drop   (drop)
    );

    // Register the per-byte report for bytes that began while locked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_bits  <= '0;
        end else begin
            err_valid <= pay_ok && locked;
            err_bits  <= (pay_ok && locked) ? err_cnt : '0;
        end
    end

    // Lock status is the tracker's phase register
    always_comb begin
        prbs_locked = locked;
    end
endmodule

// File: rtl/ts_prbs_checker_chk.sv
// Temporal checks on the checker's ports, bound into every instance.
module ts_prbs_checker_chk #(
    parameter int BYTE_W = 8,
    parameter int ERR_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sop,
    input logic              prbs_locked,
    input logic              err_valid,
    input logic [ERR_W-1:0]  err_bits
);
    // R4
    report_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $past(prbs_locked));

    // R1
    report_from_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $past(in_valid && !in_sop));

    // R5
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> err_bits <= ERR_W'(BYTE_W));

    // R5
    count_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> err_bits == '0);

    // R3
    lock_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prbs_locked) |-> $past(in_valid && !in_sop) && !err_valid);

    // R8
    drop_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prbs_locked) |-> err_valid && err_bits != '0);

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !prbs_locked && !err_valid);
endmodule

bind ts_prbs_checker ts_prbs_checker_chk #(.BYTE_W(BYTE_W), .ERR_W(ERR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sop     (in_sop),
    .prbs_locked(prbs_locked),
    .err_valid  (err_valid),
    .err_bits   (err_bits)
);

// File: tb/ts_prbs_checker_bench.sv
// Self-checking bench: sweeps header sizes, error weights and window limits.
module ts_prbs_checker_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] hdr_len = 4'd3;
    logic [7:0] in_byte = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_sop = 1'b0;
    logic       prbs_locked;
    logic       err_valid;
    logic [3:0] err_bits;

    int total = 0;
    int bad = 0;
    logic [22:0] gen = 23'h5A5A5;
    int pktpos = 0;
    int hdr = 3;
    int nbytes = 0;
    int jlock = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ts_prbs_checker u_ts_prbs_checker (
        .clk(clk), .rst_n(rst_n), .hdr_len(hdr_len), .in_byte(in_byte),
        .in_valid(in_valid), .in_sop(in_sop), .prbs_locked(prbs_locked),
        .err_valid(err_valid), .err_bits(err_bits)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference sequence: each bit is the XOR of bits 23 and 18 earlier
    function automatic logic [7:0] prbs_byte();
        logic [7:0] b;
        for (int i = 7; i >= 0; i--) begin
            b[i] = gen[22] ^ gen[17];
            gen = {gen[21:0], b[i]};
        end
        return b;
    endfunction

    // Drive one byte for one clock and settle two time units after the edge
    task automatic drive(input logic [7:0] b, input logic v, input logic s);
        in_byte = b; in_valid = v; in_sop = s;
        @(posedge clk); #2;
        in_valid = 1'b0; in_sop = 1'b0;
    endtask

    // Emit the next byte of the packet stream; payload bytes carry PRBS ^ mask
    task automatic next_byte(input logic [7:0] mask, output bit is_pay);
        is_pay = 0;
        nbytes++;
        if (nbytes % 13 == 0)
            drive(8'hA5, 1'b0, 1'b1);          // idle with stray sop: ignored
        if (pktpos == 0)
            drive(8'h47, 1'b1, 1'b1);
        else if (pktpos <= hdr)
            drive(8'h3C ^ 8'(pktpos), 1'b1, 1'b0);
        else begin
            drive(prbs_byte() ^ mask, 1'b1, 1'b0);
            is_pay = 1;
        end
        pktpos = (pktpos == 187) ? 0 : pktpos + 1;
        if (!is_pay)
            chk(err_valid == 1'b0, "R1 non-payload byte reported", int'(err_valid), 0);
    endtask

    // Send up to and including the next payload byte
    task automatic pay(input logic [7:0] mask);
        bit p;
        p = 0;
        while (!p) next_byte(mask, p);
        if (err_valid) jlock++;
    endtask

    task automatic align_window();
        while (jlock % 32 != 0) begin
            pay(8'h00);
            chk(err_valid && err_bits == 0, "R6 clean byte", int'(err_bits), 0);
        end
    endtask

    // Clean acquisition: unlocked through 10 payload bytes, locked after 11th
    task automatic acquire(input string tag);
        for (int k = 1; k <= 10; k++) begin
            pay(8'h00);
            chk(!prbs_locked && !err_valid, tag, int'(prbs_locked), 0);
        end
        pay(8'h00);
        chk(prbs_locked && !err_valid, tag, int'(prbs_locked), 1);
        jlock = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        bit p;
        int cnt;
        int errs;
        repeat (3) @(posedge clk);
        #2;
        // R9: held in reset
        chk(!prbs_locked && !err_valid && err_bits == 0, "R9 reset state", int'(prbs_locked), 0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk(!prbs_locked && !err_valid, "R9 after reset", int'(err_valid), 0);

        // R1: bytes before the first sop are ignored
        for (int k = 0; k < 5; k++) begin
            drive(8'h96 + 8'(k), 1'b1, 1'b0);
            chk(!prbs_locked && !err_valid, "R1 pre-sop byte", int'(err_valid), 0);
        end

        // R3 and R2: acquisition timing on a clean stream
        acquire("R3 acquisition timing");

        // R4 and R2: clean locked bytes report zero errors
        for (int k = 0; k < 60; k++) begin
            pay(8'h00);
            chk(err_valid && err_bits == 0, "R4 clean locked byte", int'(err_bits), 0);
        end

        // R5 and R6: error weight sweep, each followed by a clean byte
        for (int w = 1; w <= 8; w++) begin
            align_window();
            pay(8'((1 << w) - 1));
            chk(err_valid && err_bits == 4'(w), "R5 error weight", int'(err_bits), w);
            pay(8'h00);
            chk(err_valid && err_bits == 0, "R6 clean after errors", int'(err_bits), 0);
        end

        // R7: exactly 32 errors in one window keeps lock
        align_window();
        for (int k = 0; k < 4; k++) begin
            pay(8'hFF);
            chk(prbs_locked && err_bits == 8, "R7 32 errors keep lock", int'(prbs_locked), 1);
        end

        // R8: 33 errors in a window drop lock on the offending byte
        align_window();
        for (int k = 0; k < 4; k++) pay(8'hFF);
        chk(prbs_locked == 1'b1, "R8 lock before limit", int'(prbs_locked), 1);
        pay(8'h10);
        chk(!prbs_locked && err_valid && err_bits == 1, "R8 drop on byte", int'(prbs_locked), 0);
        acquire("R8 reacquisition timing");

        // R10 and R1: header size sweep, checked bytes per packet
        for (int h = 0; h < 16; h++) begin
            while (pktpos != 0) next_byte(8'h00, p);
            hdr = h;
            hdr_len = 4'(h);
            cnt = 0;
            errs = 0;
            do begin
                next_byte(8'h00, p);
                if (err_valid) begin
                    cnt++;
                    errs += int'(err_bits);
                end
            end while (pktpos != 0);
            chk(cnt == 187 - h, "R10 checked bytes per packet", cnt, 187 - h);
            chk(errs == 0 && prbs_locked, "R1 header and sync unchecked", errs, 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule